// File: doc/BRIEF.md
# Reciprocal Estimate Unit

This block takes one 64-bit IEEE-754 double operand and returns a coarse estimate of its reciprocal, meant to seed a software or hardware refinement loop. The estimate comes from a read-only table addressed by the leading fraction bits of the operand. The exponent of the result is the negation of the operand's exponent, adjusted so that the result is normalized. Operands that are zero, infinite or not-a-number take a short path that never touches the table. Subnormal operands are first renormalized so that they index the table like normal numbers.

Both sides of the block are valid/ready streams. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle, so at most one operation is in flight. A result is offered with `out_valid` and stays unchanged until a clock edge where `out_ready` is high. The unit does not accept a new operand before that edge. The four status flags travel with the result and are valid whenever `out_valid` is high.

Top module: `recip_est`

## Requirements
- R1: `in_ready` is high exactly when no operation is in flight. After an operand is accepted, `in_ready` stays low until the result has been taken. While `out_valid` is high and `out_ready` is low, the result and flags hold steady. Operands presented while busy are not accepted.
- R2: An operand of zero (exponent field and fraction both zero) yields an infinity of the same sign (0x7FF0000000000000 or 0xFFF0000000000000) and raises `out_zero_div`. No other case raises it.
- R3: An infinite operand (exponent field all ones, fraction zero) yields a zero of the same sign, with no flag raised.
- R4: A NaN operand (exponent field all ones, fraction nonzero) is returned with its payload and sign kept and bit 51 forced to one. `out_invalid_snan` is raised exactly when bit 51 of the operand was zero.
- R5: `out_frac_rounded` and `out_frac_inexact` are zero on every result.
- R6: For a normal operand with biased exponent E and sign s, the result is {s, 2045-E, F}. Here F is the low EST_W-1 bits of floor(2^(EST_W+IDX_W+1) / (2^(IDX_W+1)+2i+1)) followed by zeros, and i is the top IDX_W fraction bits (bits 51 downward). With the defaults, 1.0 gives 0x3FEFF00400000000, -1.0 gives 0xBFEFF00400000000 and 3.0 gives 0x3FD54E3800000000.
- R7: For every finite nonzero operand whose result is in range, the result times the operand differs from 1 by less than 1/512.
- R8: A subnormal operand is shifted left until its leading one becomes the hidden bit. The shifted fraction then indexes the table. The result's biased exponent is 2045 plus the number of leading zeros in the 52-bit fraction.
- R9: A result biased exponent above 2046 gives a signed infinity, and one below 1 gives a signed zero. Neither case raises a flag.
- R10: `out_valid` rises 1 clock edge after acceptance for zero, infinite and NaN operands. It rises 3 edges after acceptance for normal operands and 4 edges after for subnormal ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle and able to take an operand |
| in_operand | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Double-precision reciprocal estimate |
| out_invalid_snan | output | 1 | Operand was a signaling NaN |
| out_zero_div | output | 1 | Operand was zero |
| out_frac_rounded | output | 1 | Fraction-rounded status, always zero |
| out_frac_inexact | output | 1 | Fraction-inexact status, always zero |

## Verification
The bench builds the unit with its defaults: an 8-bit table index and 19-bit entries. This is the configuration that reproduces the listed reference encodings. With only 256 table cells, every cell is driven at both ends of its input interval. The low end uses exponent 1.0, and the high end sweeps exponents from 1 to 2044. This covers the exact encoding and the 1/512 error bound over the whole table. Because the exponent path has only a few thousand values, its edges are hit directly: both range limits for normal inputs, and subnormals on either side of the overflow threshold.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  localparam int DW     = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
  } fp_class_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_RENORM, ST_FETCH, ST_PACK, ST_HOLD
  } seq_state_e;

  typedef struct packed {
    logic inv_snan;
    logic zdiv;
  } rcp_flags_t;
endpackage

// File: rtl/rcp_classify.sv
module rcp_classify
  import rcp_pkg::*;
(
  input  logic [DW-1:0]     op,
  output fp_class_e         cls,
  output logic              sign,
  output logic [EXP_W-1:0]  bexp,
  output logic [FRAC_W-1:0] frac
);
  logic exp_ones, exp_zero, frac_zero;

  assign sign      = op[DW-1];
  assign bexp      = op[DW-2 -: EXP_W];
  assign frac      = op[FRAC_W-1:0];
  assign exp_ones  = &bexp;
  assign exp_zero  = ~|bexp;
  assign frac_zero = ~|frac;

  always_comb begin
    if (exp_ones) begin
      if (frac_zero)           cls = CLS_INF;
      else if (frac[FRAC_W-1]) cls = CLS_QNAN;
      else                     cls = CLS_SNAN;
    end else if (exp_zero) begin
      cls = frac_zero ? CLS_ZERO : CLS_SUB;
    end else begin
      cls = CLS_NORM;
    end
  end
endmodule

// File: rtl/rcp_lzc.sv
module rcp_lzc #(
  parameter int W  = 52,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  // Scan from the least significant bit up; the last set bit seen is the
  // leading one, so its distance from the top is the zero count.
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/rcp_table.sv
module rcp_table #(
  parameter int IDX_W = 8,
  parameter int EST_W = 19,
  localparam int DEPTH = 1 << IDX_W,
  localparam int OUT_W = EST_W - 1
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] addr,
  output logic [OUT_W-1:0] data
);
  // Each cell holds the reciprocal of its interval midpoint, truncated.
  // The leading one is always set and so is not stored.
  function automatic logic [OUT_W-1:0] cell_value(input int unsigned k);
    logic [63:0] numer, denom, quot;
    numer = 64'd1 << (EST_W + IDX_W + 1);
    denom = (64'd1 << (IDX_W + 1)) + 64'(2 * k + 1);
    quot  = numer / denom;
    return quot[OUT_W-1:0];
  endfunction

  logic [OUT_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign rom[g] = cell_value(g);
  end

  always_ff @(posedge clk) begin
    if (rd_en) data <= rom[addr];
  end
endmodule

// File: rtl/recip_est.sv
module recip_est
  import rcp_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int EST_W = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [63:0]   in_operand,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_result,
  output logic          out_invalid_snan,
  output logic          out_zero_div,
  output logic          out_frac_rounded,
  output logic          out_frac_inexact
);
  localparam int EXW   = EXP_W + 2;
  localparam int LZ_W  = $clog2(FRAC_W + 1);
  localparam int PAD_W = FRAC_W - (EST_W - 1);
  localparam logic signed [EXW-1:0] NORM_BASE = EXW'((1 << EXP_W) - 3);
  localparam logic signed [EXW-1:0] EXP_TOP   = EXW'((1 << EXP_W) - 2);
  localparam logic [DW-1:0] QUIET_BIT = DW'(1) << (FRAC_W - 1);

  seq_state_e              state_q;
  logic [DW-1:0]           op_q;
  logic [DW-1:0]           result_q;
  rcp_flags_t              flags_q;
  logic                    sign_q;
  logic signed [EXW-1:0]   exp_q;
  logic [IDX_W-1:0]        idx_q;

  fp_class_e               cls;
  logic                    op_sign;
  logic [EXP_W-1:0]        op_bexp;
  logic [FRAC_W-1:0]       op_frac;
  logic [LZ_W-1:0]         lz;
  logic [LZ_W-1:0]         shamt;
  logic [EST_W-2:0]        est;
  logic [FRAC_W-1:0]       packed_frac;
  logic                    take_in;

  rcp_classify u_classify (
    .op   (op_q),
    .cls  (cls),
    .sign (op_sign),
    .bexp (op_bexp),
    .frac (op_frac)
  );

  rcp_lzc #(.W(FRAC_W)) u_lzc (
    .vec   (op_frac),
    .count (lz)
  );

  rcp_table #(.IDX_W(IDX_W), .EST_W(EST_W)) u_table (
    .clk   (clk),
    .rd_en (state_q == ST_FETCH),
    .addr  (idx_q),
    .data  (est)
  );

  // Place the stored estimate bits at the top of the result fraction.
  if (PAD_W > 0) begin : g_pad
    assign packed_frac = {est, {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign packed_frac = est;
  end

  assign shamt   = lz + LZ_W'(1);
  assign take_in = in_valid && in_ready;

  assign in_ready         = (state_q == ST_IDLE);
  assign out_valid        = (state_q == ST_HOLD);
  assign out_result       = result_q;
  assign out_invalid_snan = flags_q.inv_snan;
  assign out_zero_div     = flags_q.zdiv;
  // This operation never rounds the fraction, so both bits read zero.
  assign out_frac_rounded = 1'b0;
  assign out_frac_inexact = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      result_q <= '0;
      flags_q  <= '0;
      sign_q   <= 1'b0;
      exp_q    <= '0;
      idx_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_in) begin
            op_q    <= in_operand;
            flags_q <= '0;
            state_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          sign_q <= op_sign;
          unique case (cls)
            CLS_ZERO: begin
              result_q     <= {op_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
              flags_q.zdiv <= 1'b1;
              state_q      <= ST_HOLD;
            end
            CLS_INF: begin
              result_q <= {op_sign, {(DW-1){1'b0}}};
              state_q  <= ST_HOLD;
            end
            CLS_QNAN: begin
              result_q <= op_q;
              state_q  <= ST_HOLD;
            end
            CLS_SNAN: begin
              result_q         <= op_q | QUIET_BIT;
              flags_q.inv_snan <= 1'b1;
              state_q          <= ST_HOLD;
            end
            CLS_NORM: begin
              exp_q   <= NORM_BASE - $signed(EXW'(op_bexp));
              idx_q   <= op_frac[FRAC_W-1 -: IDX_W];
              state_q <= ST_FETCH;
            end
            default: begin
              state_q <= ST_RENORM;
            end
          endcase
        end
        ST_RENORM: begin
          exp_q   <= NORM_BASE + $signed(EXW'(lz));
          idx_q   <= IDX_W'((op_frac << shamt) >> (FRAC_W - IDX_W));
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          state_q <= ST_PACK;
        end
        ST_PACK: begin
          if (exp_q > EXP_TOP)
            result_q <= {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          else if (exp_q < EXW'(1))
            result_q <= {sign_q, {(DW-1){1'b0}}};
          else
            result_q <= {sign_q, exp_q[EXP_W-1:0], packed_frac};
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/recip_est_chk.sv
module recip_est_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_operand,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_invalid_snan,
  input logic        out_zero_div
);
  logic [63:0] sh;
  logic [2:0]  wait_cnt;
  logic        sh_zero, sh_inf, sh_nan, sh_norm_in;
  logic [2:0]  exp_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      wait_cnt <= '0;
    end else if (in_valid && in_ready) begin
      sh       <= in_operand;
      wait_cnt <= '0;
    end else if (!out_valid && wait_cnt != 3'd7) begin
      wait_cnt <= wait_cnt + 3'd1;
    end
  end

  assign sh_zero    = (sh[62:0] == 63'd0);
  assign sh_inf     = (sh[62:52] == 11'h7FF) && (sh[51:0] == 52'd0);
  assign sh_nan     = (sh[62:52] == 11'h7FF) && (sh[51:0] != 52'd0);
  assign sh_norm_in = (sh[62:52] != 11'h000) && (sh[62:52] < 11'h7FD);
  assign exp_wait   = (sh[62:52] == 11'h7FF || sh_zero) ? 3'd1 :
                      (sh[62:52] != 11'h000) ? 3'd3 : 3'd4;

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_zero_div) && $stable(out_invalid_snan)); // R1
  AST_NO_INTAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R1
  AST_ZERO_TO_INF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sh_zero |-> out_result == {sh[63], 11'h7FF, 52'd0} && out_zero_div); // R2
  AST_ZDIV_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero_div |-> sh_zero); // R2
  AST_INF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sh_inf |-> out_result == {sh[63], 63'd0}
      && !out_zero_div && !out_invalid_snan); // R3
  AST_NAN_QUIETED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sh_nan |-> out_result == (sh | 64'h0008000000000000)
      && (out_invalid_snan == !sh[51])); // R4
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result[63] == sh[63]); // R6
  AST_NORMAL_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sh_norm_in |-> out_result[62:52] == 11'h7FD - sh[62:52]); // R6
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> wait_cnt == exp_wait); // R10
endmodule

bind recip_est recip_est_chk chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .in_ready         (in_ready),
  .in_operand       (in_operand),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_result       (out_result),
  .out_invalid_snan (out_invalid_snan),
  .out_zero_div     (out_zero_div)
);

// File: tb/recip_est_test.sv
module recip_est_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;
  logic        out_invalid_snan, out_zero_div, out_frac_rounded, out_frac_inexact;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  recip_est uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_operand,
    .out_valid, .out_ready, .out_result,
    .out_invalid_snan, .out_zero_div, .out_frac_rounded, .out_frac_inexact
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one operand, wait for the result, take it. Starts and ends at a negedge.
  task automatic run_op(input logic [63:0] op, output logic [63:0] res,
                        output logic vx, output logic zx, output int lat);
    in_operand = op;
    in_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!out_valid && lat < 40);
    res = out_result;
    vx  = out_invalid_snan;
    zx  = out_zero_div;
    check(!out_frac_rounded && !out_frac_inexact, "R5", "fr/fi flags",
          {62'd0, out_frac_rounded, out_frac_inexact}, 64'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic logic [63:0] expect_normal(input logic [63:0] op);
    logic [63:0] ent;
    logic [10:0] e;
    e   = op[62:52];
    ent = (64'd1 << 28) / (64'd512 + 64'(2 * op[51:44]) + 64'd1);
    return {op[63], 11'(2045 - int'(e)), ent[17:0], 34'd0};
  endfunction

  task automatic exact(input logic [63:0] op, input logic [63:0] exp,
                       input logic exp_vx, input logic exp_zx, input int exp_lat,
                       input string req);
    logic [63:0] r;
    logic vx, zx;
    int lat;
    run_op(op, r, vx, zx, lat);
    check(r == exp, req, $sformatf("result for %h", op), r, exp);
    check(vx == exp_vx && zx == exp_zx, req, "flags {vx,zx}",
          {62'd0, vx, zx}, {62'd0, exp_vx, exp_zx});
    check(lat == exp_lat, "R10", $sformatf("latency for %h", op),
          64'(lat), 64'(exp_lat));
  endtask

  task automatic err_bound(input logic [63:0] op, input string req);
    logic [63:0] r;
    logic vx, zx;
    int lat;
    real prod;
    run_op(op, r, vx, zx, lat);
    prod = $bitstoreal(r) * $bitstoreal(op) - 1.0;
    if (prod < 0.0) prod = -prod;
    check(prod < 1.0 / 512.0, "R7", $sformatf("error bound for %h (%s)", op, req),
          r, op);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] r0;
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset {in_ready,out_valid}",
          {62'd0, in_ready, out_valid}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero operands
    exact(64'h0000000000000000, 64'h7FF0000000000000, 1'b0, 1'b1, 1, "R2");
    exact(64'h8000000000000000, 64'hFFF0000000000000, 1'b0, 1'b1, 1, "R2");
    // R3: infinities
    exact(64'hFFF0000000000000, 64'h8000000000000000, 1'b0, 1'b0, 1, "R3");
    exact(64'h7FF0000000000000, 64'h0000000000000000, 1'b0, 1'b0, 1, "R3");
    // R4: quiet and signaling NaNs
    exact(64'h7FF8000000000123, 64'h7FF8000000000123, 1'b0, 1'b0, 1, "R4");
    exact(64'h7FF0000000000ABC, 64'h7FF8000000000ABC, 1'b1, 1'b0, 1, "R4");
    exact(64'hFFF4000000000001, 64'hFFFC000000000001, 1'b1, 1'b0, 1, "R4");

    // R6: reference encodings
    exact(64'h3FF0000000000000, 64'h3FEFF00400000000, 1'b0, 1'b0, 3, "R6");
    exact(64'hBFF0000000000000, 64'hBFEFF00400000000, 1'b0, 1'b0, 3, "R6");
    exact(64'h4008000000000000, 64'h3FD54E3800000000, 1'b0, 1'b0, 3, "R6");

    // R6, R7: every table cell at both ends of its interval
    for (int i = 0; i < 256; i++) begin
      logic [63:0] lo, hi;
      logic [10:0] e;
      e  = 11'(1 + (i * 37) % 2044);
      lo = {1'b0, 11'h3FF, 8'(i), 44'd0};
      hi = {1'(i), e, 8'(i), {44{1'b1}}};
      exact(lo, expect_normal(lo), 1'b0, 1'b0, 3, "R6");
      exact(hi, expect_normal(hi), 1'b0, 1'b0, 3, "R6");
      err_bound(lo, "R6 low end");
      err_bound(hi, "R6 high end");
    end

    // R8: subnormal operands
    exact(64'h0008000000000000, 64'h7FDFF00400000000, 1'b0, 1'b0, 4, "R8");
    exact(64'h000C000000000000, 64'h7FD54E3800000000, 1'b0, 1'b0, 4, "R8");
    exact(64'h8004000000000000, 64'hFFEFF00400000000, 1'b0, 1'b0, 4, "R8");
    err_bound(64'h000C000000000000, "R8 subnormal");

    // R9: range limits
    exact(64'h0002000000000000, 64'h7FF0000000000000, 1'b0, 1'b0, 4, "R9");
    exact(64'h8000000000000001, 64'hFFF0000000000000, 1'b0, 1'b0, 4, "R9");
    exact(64'h7FE0000000000000, 64'h0000000000000000, 1'b0, 1'b0, 3, "R9");
    exact(64'hFFEFFFFFFFFFFFFF, 64'h8000000000000000, 1'b0, 1'b0, 3, "R9");
    exact(64'h7FD0000000000000, 64'h0000000000000000, 1'b0, 1'b0, 3, "R9");
    exact(64'h7FC0000000000000, 64'h001FF00400000000, 1'b0, 1'b0, 3, "R9");
    exact(64'h0010000000000000, 64'h7FCFF00400000000, 1'b0, 1'b0, 3, "R9");

    // R1: back-pressure, and an operand offered while busy is not taken
    in_operand = 64'h4008000000000000;
    in_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!out_valid && lat < 40);
    r0 = out_result;
    in_operand = 64'h0000000000000000;
    in_valid   = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(out_valid && !in_ready && out_result == r0, "R1", "hold under back-pressure",
            out_result, r0);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R1", "release {out_valid,in_ready}",
          {62'd0, out_valid, in_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R1", "busy-time operand not queued",
          {62'd0, out_valid, in_ready}, 64'd1);
    exact(64'h3FF0000000000000, 64'h3FEFF00400000000, 1'b0, 1'b0, 3, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule